// File: doc/BRIEF.md
# Stereo Audio Playout DMA Engine

The block plays 16-bit stereo PCM from memory to a serial DAC. Software programs a byte address and then a byte length through a small word-indexed register file. The length write is what hands the buffer to the engine. The engine keeps two transfer slots, an active one and a queued one. It reads one 32-bit stereo frame per sample period over a request/valid memory port, and it shifts each frame out MSB first, left channel then right, on a bit clock with a word-select line.

An interrupt is raised each time a buffer enters the active slot. This happens either because the engine was idle when the length was written, or because the queued buffer was promoted when the active one drained. Software therefore refills one buffer ahead of what is playing. If nothing is queued when the active buffer drains, the engine goes idle and keeps repeating the last frame.

Top module: `pcm_dma_out`

## Requirements
- R1: After reset, status reads 0, `irq_o`, `mem_req_o`, `dac_sclk_o` and `dac_lrck_o` are 0.
- R2: Register word index 2 is control (bit 0 = enable), 3 is status, 4 is the sample divider (14 bits), 5 is the bit-clock divider (4 bits). Reads of 2, 4 and 5 return the written value masked to the field width.
- R3: A write to index 1 (length) queues a transfer at the address last written to index 0. The low 3 bits of both the address and the length are ignored. A length that is 0 after masking is ignored.
- R4: Status bit 31 reads 1 when a transfer waits in the queued slot. Status bit 30 reads 1 when the active slot holds a transfer. All other status bits read 0.
- R5: A length write while status bit 31 is set is ignored.
- R6: `irq_o` rises in the cycle a buffer enters the active slot. Any write to index 3 clears it, unless a buffer enters the active slot in that same cycle.
- R7: While enabled and busy, the engine reads consecutive 4-byte words of the active buffer in ascending order, one request per sample. `mem_req_o` stays high with `mem_addr_o` stable until `mem_valid_i`.
- R8: With control bit 0 at 0, no new request is issued. Queued and active transfers are kept and resume when the engine is re-enabled.
- R9: When the last word of the active buffer returns, a queued buffer is promoted in the same cycle. Otherwise status bit 30 clears.
- R10: A new frame starts on the serial output every (sample divider + 1) clock cycles.
- R11: Each frame is shifted as 32 bits MSB first, `mem_data_i[31:16]` (left) then `[15:0]` (right). `dac_lrck_o` is low during the left half. `dac_sclk_o` stays high and stays low for (bit divider + 1) cycles each, and data is stable at its rising edge.
- R12: When no new frame is ready at a sample boundary, the last frame is sent again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | DAC reference clock, also the register and memory clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational on `reg_addr_i` |
| mem_req_o | output | 1 | Memory read request, held until `mem_valid_i` |
| mem_addr_o | output | AW (24) | Byte address of the requested frame word |
| mem_valid_i | input | 1 | Read data valid, one pulse per request |
| mem_data_i | input | 32 | Read data: left sample in [31:16], right in [15:0] |
| dac_sclk_o | output | 1 | Serial bit clock |
| dac_lrck_o | output | 1 | Word select, low for left |
| dac_sdata_o | output | 1 | Serial data, MSB first |
| irq_o | output | 1 | Buffer-accepted interrupt |

## Verification
The properties assume that memory returns exactly one `mem_valid_i` pulse for each held request and never one without a request. They also assume that the sample period is longer than 64 bit-clock half periods, so a frame finishes shifting before the next one loads. The bench memory model answers every request after a fixed two-cycle wait. The bench runs with a sample divider of 199 and a bit divider of 1, which gives a 128-cycle frame inside a 200-cycle period. Software-side order (address before length) is kept by every bench sequence.

// File: rtl/pcm_dma_pkg.sv
package pcm_dma_pkg;
  localparam logic [2:0] REG_ADDR = 3'd0;
  localparam logic [2:0] REG_LEN  = 3'd1;
  localparam logic [2:0] REG_CTRL = 3'd2;
  localparam logic [2:0] REG_STS  = 3'd3;
  localparam logic [2:0] REG_RATE = 3'd4;
  localparam logic [2:0] REG_BCLK = 3'd5;
  localparam int STS_FULL_BIT = 31;
  localparam int STS_BUSY_BIT = 30;
  localparam int FRAME_W      = 32;
  localparam int FRAME_BYTES  = FRAME_W / 8;
  typedef logic [FRAME_W-1:0] frame_t;
endpackage

// File: rtl/pcm_div.sv
module pcm_div #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic [W-1:0] lim_i,
  output logic         tick_o
);
  logic [W-1:0] cnt_q;

  assign tick_o = !clr_i && (cnt_q >= lim_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i || tick_o)   cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pcm_xfer_queue.sv
module pcm_xfer_queue
  import pcm_dma_pkg::*;
#(
  parameter int AW = 24,
  parameter int LW = 18
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          len_we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [LW-1:0] len_i,
  output logic          busy_o,
  output logic          full_o,
  output logic          start_o,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_valid_i,
  input  frame_t        mem_data_i,
  output frame_t        frame_o,
  output logic          frame_vld_o,
  input  logic          frame_take_i
);
  localparam logic [LW-1:0] STEP_L = LW'(FRAME_BYTES);
  localparam logic [AW-1:0] STEP_A = AW'(FRAME_BYTES);

  logic          act_vld_q, pnd_vld_q, req_q, frm_vld_q;
  logic [AW-1:0] act_addr_q, pnd_addr_q;
  logic [LW-1:0] act_rem_q, pnd_len_q;
  frame_t        frm_q;
  logic          beat, last, accept, go_act;

  assign beat    = req_q && mem_valid_i;
  assign last    = beat && (act_rem_q == STEP_L);
  assign accept  = len_we_i && (len_i != '0) && !pnd_vld_q;
  // a draining active slot frees itself for a same-cycle write
  assign go_act  = !act_vld_q || last;
  assign start_o = (accept && go_act) || (last && pnd_vld_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_vld_q  <= 1'b0;
      pnd_vld_q  <= 1'b0;
      req_q      <= 1'b0;
      frm_vld_q  <= 1'b0;
      act_addr_q <= '0;
      pnd_addr_q <= '0;
      act_rem_q  <= '0;
      pnd_len_q  <= '0;
      frm_q      <= '0;
    end else begin
      if (frame_take_i) frm_vld_q <= 1'b0;
      if (en_i && act_vld_q && !req_q && !frm_vld_q) req_q <= 1'b1;
      if (beat) begin
        frm_q      <= mem_data_i;
        frm_vld_q  <= 1'b1;
        req_q      <= 1'b0;
        act_addr_q <= act_addr_q + STEP_A;
        act_rem_q  <= act_rem_q - STEP_L;
        if (last) begin
          if (pnd_vld_q) begin
            act_addr_q <= pnd_addr_q;
            act_rem_q  <= pnd_len_q;
            pnd_vld_q  <= 1'b0;
          end else begin
            act_vld_q  <= 1'b0;
          end
        end
      end
      if (accept) begin
        if (go_act) begin
          act_vld_q  <= 1'b1;
          act_addr_q <= addr_i;
          act_rem_q  <= len_i;
        end else begin
          pnd_vld_q  <= 1'b1;
          pnd_addr_q <= addr_i;
          pnd_len_q  <= len_i;
        end
      end
    end
  end

  assign busy_o      = act_vld_q;
  assign full_o      = pnd_vld_q;
  assign mem_req_o   = req_q;
  assign mem_addr_o  = act_addr_q;
  assign frame_o     = frm_q;
  assign frame_vld_o = frm_vld_q;

  // R4
  full_implies_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> busy_o);
  // R7
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_valid_i) |=> (mem_req_o && $stable(mem_addr_o)));
  // R8
  req_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_req_o) |-> $past(en_i));
  // R9
  drain_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_valid_i && act_rem_q == STEP_L && !full_o && !len_we_i)
    |=> !busy_o);
endmodule

// File: rtl/pcm_serializer.sv
module pcm_serializer
  import pcm_dma_pkg::*;
#(
  parameter int BDIV_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  frame_t            data_i,
  input  logic [BDIV_W-1:0] bdiv_i,
  output logic              sclk_o,
  output logic              lrck_o,
  output logic              sdata_o
);
  localparam int IDX_W = $clog2(FRAME_W);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_W - 1);

  logic             btick, run_q, sclk_q;
  logic [IDX_W-1:0] idx_q;
  frame_t           sh_q;

  pcm_div #(.W(BDIV_W)) u_bdiv (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (load_i),
    .lim_i  (bdiv_i),
    .tick_o (btick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      idx_q  <= '0;
      run_q  <= 1'b0;
      sclk_q <= 1'b0;
    end else if (load_i) begin
      sh_q   <= data_i;
      idx_q  <= '0;
      run_q  <= 1'b1;
      sclk_q <= 1'b0;
    end else if (run_q && btick) begin
      if (!sclk_q) begin
        sclk_q <= 1'b1;
      end else begin
        sclk_q <= 1'b0;
        sh_q   <= {sh_q[FRAME_W-2:0], 1'b0};
        idx_q  <= idx_q + 1'b1;
        if (idx_q == LAST_IDX) run_q <= 1'b0;
      end
    end
  end

  assign sclk_o  = sclk_q;
  assign lrck_o  = idx_q[IDX_W-1];
  assign sdata_o = sh_q[FRAME_W-1];

  // R11
  data_at_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_o) |-> ($stable(sdata_o) && $stable(lrck_o)));
endmodule

// File: rtl/pcm_dma_out.sv
module pcm_dma_out
  import pcm_dma_pkg::*;
#(
  parameter int AW     = 24,
  parameter int LW     = 18,
  parameter int RATE_W = 14,
  parameter int BDIV_W = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [2:0]    reg_addr_i,
  input  logic [31:0]   reg_wdata_i,
  output logic [31:0]   reg_rdata_o,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_valid_i,
  input  logic [31:0]   mem_data_i,
  output logic          dac_sclk_o,
  output logic          dac_lrck_o,
  output logic          dac_sdata_o,
  output logic          irq_o
);
  localparam int ALIGN = 3;

  logic [AW-1:ALIGN] addr_q;
  logic              en_q, irq_q;
  logic [RATE_W-1:0] rate_q;
  logic [BDIV_W-1:0] bdiv_q;
  frame_t            last_q, frame, ser_data;
  logic              busy, full, start, frame_vld, stick, take;
  logic              wr_addr, wr_len, wr_ctrl, wr_sts, wr_rate, wr_bclk;
  logic              unused_wdata;

  assign wr_addr = reg_we_i && (reg_addr_i == REG_ADDR);
  assign wr_len  = reg_we_i && (reg_addr_i == REG_LEN);
  assign wr_ctrl = reg_we_i && (reg_addr_i == REG_CTRL);
  assign wr_sts  = reg_we_i && (reg_addr_i == REG_STS);
  assign wr_rate = reg_we_i && (reg_addr_i == REG_RATE);
  assign wr_bclk = reg_we_i && (reg_addr_i == REG_BCLK);
  assign unused_wdata = ^reg_wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      en_q   <= 1'b0;
      rate_q <= '0;
      bdiv_q <= '0;
      irq_q  <= 1'b0;
      last_q <= '0;
    end else begin
      if (wr_addr) addr_q <= reg_wdata_i[AW-1:ALIGN];
      if (wr_ctrl) en_q   <= reg_wdata_i[0];
      if (wr_rate) rate_q <= reg_wdata_i[RATE_W-1:0];
      if (wr_bclk) bdiv_q <= reg_wdata_i[BDIV_W-1:0];
      if (start)       irq_q <= 1'b1;
      else if (wr_sts) irq_q <= 1'b0;
      if (take)    last_q <= frame;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      REG_CTRL: reg_rdata_o[0] = en_q;
      REG_STS: begin
        reg_rdata_o[STS_FULL_BIT] = full;
        reg_rdata_o[STS_BUSY_BIT] = busy;
      end
      REG_RATE: reg_rdata_o[RATE_W-1:0] = rate_q;
      REG_BCLK: reg_rdata_o[BDIV_W-1:0] = bdiv_q;
      default: ;
    endcase
  end

  pcm_xfer_queue #(.AW(AW), .LW(LW)) u_queue (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (en_q),
    .len_we_i     (wr_len),
    .addr_i       ({addr_q, {ALIGN{1'b0}}}),
    .len_i        ({reg_wdata_i[LW-1:ALIGN], {ALIGN{1'b0}}}),
    .busy_o       (busy),
    .full_o       (full),
    .start_o      (start),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .mem_valid_i  (mem_valid_i),
    .mem_data_i   (mem_data_i),
    .frame_o      (frame),
    .frame_vld_o  (frame_vld),
    .frame_take_i (take)
  );

  pcm_div #(.W(RATE_W)) u_rate (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (1'b0),
    .lim_i  (rate_q),
    .tick_o (stick)
  );

  assign take     = stick && frame_vld;
  assign ser_data = frame_vld ? frame : last_q;

  pcm_serializer #(.BDIV_W(BDIV_W)) u_ser (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (stick),
    .data_i  (ser_data),
    .bdiv_i  (bdiv_q),
    .sclk_o  (dac_sclk_o),
    .lrck_o  (dac_lrck_o),
    .sdata_o (dac_sdata_o)
  );

  assign irq_o = irq_q;

  // R6
  irq_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> irq_o);
  // R6
  irq_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_sts && !start) |=> !irq_o);
endmodule

// File: tb/tb_pcm_dma_out.sv
module tb_pcm_dma_out;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [2:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        mem_req_o;
  logic [23:0] mem_addr_o;
  logic        mem_valid_i = 1'b0;
  logic [31:0] mem_data_i = '0;
  logic        dac_sclk_o, dac_lrck_o, dac_sdata_o, irq_o;

  pcm_dma_out dut (.*);

  always #5 clk_i = ~clk_i;

  int nchk = 0, nerr = 0, cyc = 0;
  int nreq = 0, lat = 0;
  logic [23:0] mlog [0:63];
  logic [31:0] cap [0:63];
  int capt [0:63];
  int ncap = 0, bitn = 0, t0 = 0, last_rise = 0, lr_err = 0, hp_err = 0;
  bit cap_on = 0, prev_sclk = 0;
  logic [31:0] shw = '0;

  function automatic logic [31:0] dval(logic [23:0] a);
    return {a[15:0] ^ 16'hA5A5, a[15:0] + 16'h1357};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk_i);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic wait_idle(output bit ok);
    logic [31:0] s;
    ok = 0;
    for (int i = 0; i < 5000; i++) begin
      rd(3'd3, s);
      if (!s[30]) begin ok = 1; break; end
    end
  endtask

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      nerr++;
      $display("FAIL watchdog all-requirements act=hung exp=done");
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  // memory model: two-cycle wait, one valid pulse per request
  always @(negedge clk_i) begin
    if (mem_valid_i) mem_valid_i = 1'b0;
    else if (rst_ni && mem_req_o) begin
      if (lat == 1) begin
        mem_valid_i = 1'b1;
        mem_data_i  = dval(mem_addr_o);
        mlog[nreq % 64] = mem_addr_o;
        nreq++;
        lat = 0;
      end else lat++;
    end
  end

  // serial capture at bit-clock rising edges
  always @(negedge clk_i) begin
    if (dac_sclk_o && !prev_sclk) begin
      if (cyc - last_rise > 16) bitn = 0;
      last_rise = cyc;
      if (bitn == 0) begin
        t0 = cyc;
        if (cap_on && dac_lrck_o) lr_err++;
      end
      if (bitn == 1 && cap_on && (cyc - t0) != 4) hp_err++;
      if (bitn == 16 && cap_on && !dac_lrck_o) lr_err++;
      shw = {shw[30:0], dac_sdata_o};
      bitn++;
      if (bitn == 32) begin
        if (cap_on && ncap < 64) begin
          cap[ncap] = shw; capt[ncap] = t0; ncap++;
        end
        bitn = 0;
      end
    end
    prev_sclk = dac_sclk_o;
  end

  // {index, write data, expected readback}
  localparam logic [66:0] VEC [0:6] = '{
    {3'd2, 32'hFFFF_FFFE, 32'h0000_0000},
    {3'd2, 32'h0000_0001, 32'h0000_0001},
    {3'd4, 32'hFFFF_FFFF, 32'h0000_3FFF},
    {3'd5, 32'hFFFF_FFF3, 32'h0000_0003},
    {3'd4, 32'd199,       32'd199},
    {3'd5, 32'h0000_0001, 32'h0000_0001},
    {3'd2, 32'h0000_0000, 32'h0000_0000}
  };

  initial begin
    logic [31:0] s;
    bit ok;
    int k, base, n1;
    logic [23:0] exp_a [0:5];
    exp_a = '{24'h1000, 24'h1004, 24'h1008, 24'h100C, 24'h2000, 24'h2004};

    repeat (3) @(negedge clk_i);
    // R1 reset state
    rd(3'd3, s);
    chk(s == 0, "R1 status", s, 0);
    chk({irq_o, mem_req_o, dac_sclk_o, dac_lrck_o} == 0, "R1 outputs",
        {28'd0, irq_o, mem_req_o, dac_sclk_o, dac_lrck_o}, 0);
    rst_ni = 1'b1;

    // R2 register table
    for (int i = 0; i < 7; i++) begin
      wr(VEC[i][66:64], VEC[i][63:32]);
      rd(VEC[i][66:64], s);
      chk(s == VEC[i][31:0], "R2 readback", s, VEC[i][31:0]);
    end

    repeat (600) @(negedge clk_i);
    cap_on = 1; ncap = 0;

    // R3 R4 R6: direct start while disabled, unaligned address and length
    wr(3'd0, 32'h1005);
    wr(3'd1, 32'h17);
    rd(3'd3, s);
    chk(s == 32'h4000_0000, "R3/R4 busy after length", s, 32'h4000_0000);
    chk(irq_o == 1, "R6 irq on direct start", {31'd0, irq_o}, 1);
    repeat (50) @(negedge clk_i);
    chk(nreq == 0, "R8 no fetch while disabled", nreq, 0);
    wr(3'd3, 32'h0);
    chk(irq_o == 0, "R6 irq cleared by status write", {31'd0, irq_o}, 0);
    wr(3'd0, 32'h2000);
    wr(3'd1, 32'h8);
    rd(3'd3, s);
    chk(s == 32'hC000_0000, "R4 full and busy", s, 32'hC000_0000);
    wr(3'd0, 32'h3000);
    wr(3'd1, 32'h8);
    rd(3'd3, s);
    chk(s == 32'hC000_0000, "R5 write while full", s, 32'hC000_0000);

    wr(3'd2, 32'h1);
    wait_idle(ok);
    chk(ok, "R9 idle after drain", {31'd0, ok}, 1);
    chk(irq_o == 1, "R6 irq on promotion", {31'd0, irq_o}, 1);
    chk(nreq == 6, "R5/R9 fetch count", nreq, 6);
    for (int i = 0; i < 6; i++)
      chk(mlog[i] == exp_a[i], "R7 fetch order", {8'd0, mlog[i]}, {8'd0, exp_a[i]});
    repeat (800) @(negedge clk_i);

    // R10 R11 R12 serial stream
    k = 0;
    while (k < ncap && cap[k] == 0) k++;
    chk(k + 8 <= ncap, "R10 frames captured", ncap, k + 8);
    if (k + 8 <= ncap) begin
      for (int i = 0; i < 6; i++)
        chk(cap[k+i] == dval(exp_a[i]), "R11 frame content", cap[k+i], dval(exp_a[i]));
      chk(cap[k+6] == dval(24'h2004), "R12 hold last frame", cap[k+6], dval(24'h2004));
      chk(cap[k+7] == dval(24'h2004), "R12 hold last frame again", cap[k+7], dval(24'h2004));
      chk(capt[k+1] - capt[k] == 200, "R10 sample period", capt[k+1] - capt[k], 200);
      chk(capt[k+6] - capt[k+5] == 200, "R10 sample period at hold", capt[k+6] - capt[k+5], 200);
    end

    // R8 stop mid-buffer and resume
    wr(3'd3, 32'h0);
    base = nreq;
    wr(3'd0, 32'h4000);
    wr(3'd1, 32'h40);
    repeat (700) @(negedge clk_i);
    wr(3'd2, 32'h0);
    repeat (20) @(negedge clk_i);
    n1 = nreq;
    repeat (1000) @(negedge clk_i);
    chk(nreq == n1, "R8 no fetch after disable", nreq, n1);
    rd(3'd3, s);
    chk(s[30] == 1, "R8 transfer kept while disabled", s, 32'h4000_0000);
    wr(3'd2, 32'h1);
    wait_idle(ok);
    chk(nreq - base == 16, "R7 resumed fetch count", nreq - base, 16);
    chk(mlog[(nreq-1) % 64] == 24'h403C, "R7 last address", {8'd0, mlog[(nreq-1) % 64]}, 32'h403C);

    // R3 zero length after masking ignored
    wr(3'd3, 32'h0);
    wr(3'd1, 32'h0);
    wr(3'd1, 32'h7);
    rd(3'd3, s);
    chk(s == 0, "R3 zero length ignored", s, 0);
    chk(irq_o == 0, "R3 zero length no irq", {31'd0, irq_o}, 0);

    chk(lr_err == 0, "R11 word select", lr_err, 0);
    chk(hp_err == 0, "R11 bit clock half period", hp_err, 0);

    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule